// File: doc/BRIEF.md
# Per-Channel Programmable Gamma Corrector

This block applies a software-loaded transfer curve to each colour component of a pixel stream. Each of the three components enters as an 8-bit code and leaves as a 10-bit code. The two extra bits keep the precision that a later dither stage needs when it reduces the result to 8 or 6 bits for the panel. Red, green and blue each have their own table of 256 ten-bit entries, so the three curves are fully independent and can take any shape.

Tables are loaded through a simple write port. A single-cycle strobe carries a component select, an entry index and a 10-bit value. A per-pixel bypass control skips the tables. Instead, each input code is widened to 10 bits by appending copies of its top two bits, so the block gives a useful linear result even when no table has been loaded. The pixel path has no handshake. Every pixel comes out exactly two clock cycles after it goes in, and the data-enable and both sync markers are delayed by the same amount.

Top module: `gamma_corrector`

## Requirements
- R1: The three tables are independent: a write selecting one component never changes what the other two components return for any index.
- R2: With bypass low and data enable high, each output component equals the 10-bit entry last written to that component's table at the index given by its 8-bit input.
- R3: With bypass high, each output component equals the 8-bit input shifted left by two with input bits [7:6] placed in output bits [1:0], so 0 maps to 0, 128 maps to 514 and 255 maps to 1023. This holds with the tables never written.
- R4: Bypass is taken per pixel: consecutive pixels may alternate between bypass and table mode, and each pixel uses its own bypass value.
- R5: out_de, out_hs and out_vs equal in_de, in_hs and in_vs from two clock cycles earlier, and pixel data appears in the same cycle as its enable.
- R6: When a write and a table lookup hit the same component and index in one cycle, that lookup returns the value held before the write, and later lookups return the new value.
- R7: The write select encodes red as 0, green as 1 and blue as 2. The value 3 selects no table, and a write with it changes no entry.
- R8: Whenever out_de is low, out_r, out_g and out_b are all zero.
- R9: While reset (rst_n low) is held, and on the first cycle after it, out_de, out_hs, out_vs and all pixel outputs are zero.
- R10: Table entries change only in cycles where wr_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_de | input | 1 | Input pixel data enable |
| in_hs | input | 1 | Input horizontal sync marker |
| in_vs | input | 1 | Input vertical sync marker |
| in_r | input | 8 | Input red code |
| in_g | input | 8 | Input green code |
| in_b | input | 8 | Input blue code |
| bypass | input | 1 | Skip the tables for this pixel when high |
| wr_en | input | 1 | Table write strobe |
| wr_chan | input | 2 | Table select: 0 red, 1 green, 2 blue, 3 none |
| wr_addr | input | 8 | Table entry index |
| wr_data | input | 10 | Value to store |
| out_de | output | 1 | Output data enable, two cycles after in_de |
| out_hs | output | 1 | Output horizontal sync, two cycles after in_hs |
| out_vs | output | 1 | Output vertical sync, two cycles after in_vs |
| out_r | output | 10 | Corrected red |
| out_g | output | 10 | Corrected green |
| out_b | output | 10 | Corrected blue |

## Verification
The hardest case to reach from the ports is a write and a lookup that hit the same entry on the same clock edge. Only then does it show whether the table read sees the old contents or the new ones. The bench presents a table-mode pixel and a write to that pixel's index in the same cycle. It expects the old value two cycles later, then looks up the index again to confirm that the new value was stored. Per-pixel bypass switching is reached by streaming pixels whose bypass bit alternates. Every output is compared with the value expected for its own pixel, so a bypass bit that is sampled at the wrong pipeline stage shows up at once.

// File: rtl/gamma_pkg.sv
package gamma_pkg;

    // Encoding of the write-port table select
    typedef enum logic [1:0] {
        SEL_RED  = 2'd0,
        SEL_GRN  = 2'd1,
        SEL_BLU  = 2'd2,
        SEL_NONE = 2'd3
    } chan_sel_e;

    localparam int unsigned NUM_CHAN = 3;

endpackage

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned VAL_W  = 10,
    parameter int unsigned SEL_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VAL_W-1:0] wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VAL_W-1:0] rd_val
);
    localparam int unsigned DEPTH = 1 << IDX_W;
    localparam logic [1:0]  MY_SEL = SEL_ID[1:0];

    typedef struct packed {
        logic [VAL_W-1:0] rd;
    } bank_t;

    logic [VAL_W-1:0] store [DEPTH];
    bank_t            bank_d, bank_q;
    logic             hit;

    assign hit = wr_en && (wr_sel == MY_SEL);

    // Read sees the contents before any write on the same edge
    always_comb begin
        bank_d    = bank_q;
        bank_d.rd = store[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_ff @(posedge clk) begin
        if (hit) begin
            store[wr_idx] <= wr_val;
        end
    end

    assign rd_val = bank_q.rd;

endmodule

// File: rtl/gamma_widen.sv
module gamma_widen #(
    parameter int unsigned IN_W  = 8,
    parameter int unsigned OUT_W = 10
) (
    input  logic [IN_W-1:0]  narrow,
    output logic [OUT_W-1:0] wide
);
    localparam int unsigned PAD = OUT_W - IN_W;

    generate
        if (PAD == 0) begin : g_same
            assign wide = narrow;
        end else if (PAD <= IN_W) begin : g_repl
            // Top bits copied into the freed low bits: full scale stays full scale
            assign wide = {narrow, narrow[IN_W-1 -: PAD]};
        end else begin : g_zero
            assign wide = {narrow, {PAD{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/gamma_corrector.sv
module gamma_corrector #(
    parameter int unsigned IN_W  = 8,
    parameter int unsigned OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_de,
    input  logic             in_hs,
    input  logic             in_vs,
    input  logic [IN_W-1:0]  in_r,
    input  logic [IN_W-1:0]  in_g,
    input  logic [IN_W-1:0]  in_b,
    input  logic             bypass,
    input  logic             wr_en,
    input  logic [1:0]       wr_chan,
    input  logic [IN_W-1:0]  wr_addr,
    input  logic [OUT_W-1:0] wr_data,
    output logic             out_de,
    output logic             out_hs,
    output logic             out_vs,
    output logic [OUT_W-1:0] out_r,
    output logic [OUT_W-1:0] out_g,
    output logic [OUT_W-1:0] out_b
);
    import gamma_pkg::*;

    localparam int unsigned NCH = NUM_CHAN;

    typedef struct packed {
        logic                         de;
        logic                         hs;
        logic                         vs;
        logic                         byp;
        logic [NCH-1:0][OUT_W-1:0]    wide;
    } stg1_t;

    typedef struct packed {
        logic                         de;
        logic                         hs;
        logic                         vs;
        logic [NCH-1:0][OUT_W-1:0]    pix;
    } stg2_t;

    stg1_t s1_d, s1_q;
    stg2_t s2_d, s2_q;

    logic [NCH-1:0][IN_W-1:0]  code_w;
    logic [NCH-1:0][OUT_W-1:0] wide_w;
    logic [NCH-1:0][OUT_W-1:0] rd_w;

    assign code_w[0] = in_r;
    assign code_w[1] = in_g;
    assign code_w[2] = in_b;

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
            gamma_lut_bank #(
                .IDX_W  (IN_W),
                .VAL_W  (OUT_W),
                .SEL_ID (ch)
            ) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (wr_en),
                .wr_sel (wr_chan),
                .wr_idx (wr_addr),
                .wr_val (wr_data),
                .rd_idx (code_w[ch]),
                .rd_val (rd_w[ch])
            );

            gamma_widen #(
                .IN_W  (IN_W),
                .OUT_W (OUT_W)
            ) u_widen (
                .narrow (code_w[ch]),
                .wide   (wide_w[ch])
            );
        end
    endgenerate

    always_comb begin
        s1_d      = s1_q;
        s1_d.de   = in_de;
        s1_d.hs   = in_hs;
        s1_d.vs   = in_vs;
        s1_d.byp  = bypass;
        s1_d.wide = wide_w;

        s2_d    = s2_q;
        s2_d.de = s1_q.de;
        s2_d.hs = s1_q.hs;
        s2_d.vs = s1_q.vs;
        for (int ch = 0; ch < NCH; ch++) begin
            if (!s1_q.de) begin
                s2_d.pix[ch] = '0;
            end else if (s1_q.byp) begin
                s2_d.pix[ch] = s1_q.wide[ch];
            end else begin
                s2_d.pix[ch] = rd_w[ch];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_de = s2_q.de;
    assign out_hs = s2_q.hs;
    assign out_vs = s2_q.vs;
    assign out_r  = s2_q.pix[0];
    assign out_g  = s2_q.pix[1];
    assign out_b  = s2_q.pix[2];

endmodule

// File: rtl/gamma_corrector_chk.sv
module gamma_corrector_chk #(
    parameter int unsigned IN_W  = 8,
    parameter int unsigned OUT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_de,
    input logic             in_hs,
    input logic             in_vs,
    input logic [IN_W-1:0]  in_r,
    input logic [IN_W-1:0]  in_g,
    input logic [IN_W-1:0]  in_b,
    input logic             bypass,
    input logic             out_de,
    input logic             out_hs,
    input logic             out_vs,
    input logic [OUT_W-1:0] out_r,
    input logic [OUT_W-1:0] out_g,
    input logic [OUT_W-1:0] out_b
);
    localparam int unsigned PAD = OUT_W - IN_W;

    logic [1:0] age_q;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    assign warm = (age_q >= 2'd2);

    // R5
    sideband_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_de == $past(in_de, 2) && out_hs == $past(in_hs, 2)
                  && out_vs == $past(in_vs, 2)));

    // R8
    blank_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_de |-> (out_r == '0 && out_g == '0 && out_b == '0));

    // R3
    bypass_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_de, 2) && $past(bypass, 2)) |->
        (out_r == {$past(in_r, 2), $past(in_r[IN_W-1 -: PAD], 2)}
         && out_g == {$past(in_g, 2), $past(in_g[IN_W-1 -: PAD], 2)}
         && out_b == {$past(in_b, 2), $past(in_b[IN_W-1 -: PAD], 2)}));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_de && !out_hs && !out_vs && out_r == '0
                    && out_g == '0 && out_b == '0));

endmodule

bind gamma_corrector gamma_corrector_chk #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_de  (in_de),
    .in_hs  (in_hs),
    .in_vs  (in_vs),
    .in_r   (in_r),
    .in_g   (in_g),
    .in_b   (in_b),
    .bypass (bypass),
    .out_de (out_de),
    .out_hs (out_hs),
    .out_vs (out_vs),
    .out_r  (out_r),
    .out_g  (out_g),
    .out_b  (out_b)
);

// File: tb/gamma_corrector_bench.sv
module gamma_corrector_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0;
    logic       bypass = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_chan = '0;
    logic [7:0] wr_addr = '0;
    logic [9:0] wr_data = '0;
    logic       out_de, out_hs, out_vs;
    logic [9:0] out_r, out_g, out_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Bench model of table contents, index = chan*256 + addr
    logic [9:0] mdl [768];

    // Stream buffers
    logic       s_de [300], s_hs [300], s_vs [300], s_byp [300];
    logic [7:0] s_r [300], s_g [300], s_b [300];

    always #5 clk = ~clk;

    gamma_corrector u_gamma_corrector (
        .clk(clk), .rst_n(rst_n),
        .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .bypass(bypass),
        .wr_en(wr_en), .wr_chan(wr_chan), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    function automatic logic [9:0] widen(input logic [7:0] v);
        return {v, v[7:6]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_de = 0; in_hs = 0; in_vs = 0; bypass = 0;
        in_r = 0; in_g = 0; in_b = 0;
    endtask

    task automatic write_entry(input logic [1:0] ch, input logic [7:0] a,
                               input logic [9:0] v, input logic strobe);
        @(negedge clk);
        wr_en = strobe; wr_chan = ch; wr_addr = a; wr_data = v;
        if (strobe && ch != 2'd3) mdl[ch*256 + a] = v;
        @(negedge clk);
        wr_en = 0;
    endtask

    // Drive n buffered pixels back to back; compare each output two cycles later
    task automatic run_stream(input int n, input string req);
        for (int i = 0; i < n + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                int k = i - 2;
                logic [9:0] er, eg, eb;
                if (!s_de[k]) begin
                    er = 0; eg = 0; eb = 0;
                end else if (s_byp[k]) begin
                    er = widen(s_r[k]); eg = widen(s_g[k]); eb = widen(s_b[k]);
                end else begin
                    er = mdl[s_r[k]]; eg = mdl[256 + s_g[k]]; eb = mdl[512 + s_b[k]];
                end
                chk(out_de == s_de[k], {req, " de"}, out_de, s_de[k]);
                chk(out_hs == s_hs[k], {req, " hs"}, out_hs, s_hs[k]);
                chk(out_vs == s_vs[k], {req, " vs"}, out_vs, s_vs[k]);
                chk(out_r == er, {req, " red"}, out_r, er);
                chk(out_g == eg, {req, " green"}, out_g, eg);
                chk(out_b == eb, {req, " blue"}, out_b, eb);
            end
            if (i < n) begin
                in_de = s_de[i]; in_hs = s_hs[i]; in_vs = s_vs[i]; bypass = s_byp[i];
                in_r = s_r[i]; in_g = s_g[i]; in_b = s_b[i];
            end else begin
                idle_inputs();
            end
        end
    endtask

    // Single table-mode pixel, returns outputs two cycles later
    task automatic probe(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                         output logic [9:0] orr, output logic [9:0] og, output logic [9:0] ob);
        @(negedge clk);
        in_de = 1; bypass = 0; in_r = r; in_g = g; in_b = b;
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        orr = out_r; og = out_g; ob = out_b;
    endtask

    task automatic t_reset();
        // R9: outputs quiet during and right after reset
        @(negedge clk);
        chk(out_de == 0 && out_hs == 0 && out_vs == 0, "R9 sideband", out_de, 0);
        chk(out_r == 0 && out_g == 0 && out_b == 0, "R9 data", out_r, 0);
        rst_n = 1;
        @(negedge clk);
        chk(out_de == 0 && out_r == 0, "R9 first cycle", out_r, 0);
    endtask

    task automatic t_bypass_unprogrammed();
        // R3: bypass mapping with untouched tables, full sweep
        for (int i = 0; i < 256; i++) begin
            s_de[i] = 1; s_hs[i] = 0; s_vs[i] = 0; s_byp[i] = 1;
            s_r[i] = 8'(i); s_g[i] = 8'(255 - i); s_b[i] = 8'(i) ^ 8'h5A;
        end
        run_stream(256, "R3 bypass sweep");
        // R3: named corner values
        s_r[0] = 8'd255; s_g[0] = 8'd0; s_b[0] = 8'd128; s_byp[0] = 1; s_de[0] = 1;
        run_stream(1, "R3 corners");
        @(negedge clk);
        s_de[0] = 1; s_byp[0] = 1; s_hs[0] = 0; s_vs[0] = 0;
        s_r[0] = 8'd255; s_g[0] = 8'd0; s_b[0] = 8'd128;
        @(negedge clk);
        in_de = 1; bypass = 1; in_r = 8'd255; in_g = 8'd0; in_b = 8'd128;
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        chk(out_r == 10'd1023, "R3 full scale", out_r, 1023);
        chk(out_g == 10'd0, "R3 zero", out_g, 0);
        chk(out_b == 10'd514, "R3 mid", out_b, 514);
    endtask

    task automatic t_program();
        for (int ch = 0; ch < 3; ch++)
            for (int a = 0; a < 256; a++)
                write_entry(2'(ch), 8'(a), 10'((a * 4 + ch * 37 + (a >> 3)) & 1023), 1'b1);
    endtask

    task automatic t_table_sweep();
        // R2: every index of every table, different index per component
        for (int i = 0; i < 256; i++) begin
            s_de[i] = 1; s_hs[i] = 0; s_vs[i] = 0; s_byp[i] = 0;
            s_r[i] = 8'(i); s_g[i] = 8'(i * 7); s_b[i] = 8'(255 - i);
        end
        run_stream(256, "R2 table sweep");
    endtask

    task automatic t_independent();
        logic [9:0] r0, g0, b0, r1, g1, b1;
        // R1: writing red index 40 leaves green and blue at index 40 alone
        probe(8'd40, 8'd40, 8'd40, r0, g0, b0);
        write_entry(2'd0, 8'd40, 10'h3AA, 1'b1);
        probe(8'd40, 8'd40, 8'd40, r1, g1, b1);
        chk(r1 == 10'h3AA, "R1 red updated", r1, 10'h3AA);
        chk(g1 == g0, "R1 green untouched", g1, g0);
        chk(b1 == b0, "R1 blue untouched", b1, b0);
    endtask

    task automatic t_mixed_bypass();
        // R4: bypass toggles every pixel
        for (int i = 0; i < 64; i++) begin
            s_de[i] = 1; s_hs[i] = 0; s_vs[i] = 0; s_byp[i] = i[0];
            s_r[i] = 8'(i * 3); s_g[i] = 8'(200 - i); s_b[i] = 8'(i * 11);
        end
        run_stream(64, "R4 per-pixel bypass");
    endtask

    task automatic t_sideband();
        // R5 and R8: enable gaps and sync pulses, data must blank
        for (int i = 0; i < 80; i++) begin
            s_de[i] = (i % 10) < 6; s_hs[i] = (i % 10) == 7;
            s_vs[i] = (i >= 40 && i < 43); s_byp[i] = (i % 4) == 0;
            s_r[i] = 8'(i * 5); s_g[i] = 8'(i + 100); s_b[i] = 8'(255 - i * 2);
        end
        run_stream(80, "R5 R8 sideband and blanking");
    endtask

    task automatic t_collision();
        logic [9:0] r1, g1, b1;
        logic [9:0] old_g;
        // R6: same-cycle write and lookup of green index 77
        old_g = mdl[256 + 77];
        @(negedge clk);
        in_de = 1; bypass = 0; in_r = 8'd1; in_g = 8'd77; in_b = 8'd2;
        wr_en = 1; wr_chan = 2'd1; wr_addr = 8'd77; wr_data = 10'h155;
        @(negedge clk);
        wr_en = 0; idle_inputs();
        mdl[256 + 77] = 10'h155;
        @(negedge clk);
        chk(out_g == old_g, "R6 old value on collision", out_g, old_g);
        probe(8'd1, 8'd77, 8'd2, r1, g1, b1);
        chk(g1 == 10'h155, "R6 new value afterwards", g1, 10'h155);
    endtask

    task automatic t_bad_chan();
        logic [9:0] r0, g0, b0, r1, g1, b1;
        // R7: select 3 writes nothing
        probe(8'd10, 8'd10, 8'd10, r0, g0, b0);
        write_entry(2'd3, 8'd10, 10'h000, 1'b1);
        write_entry(2'd3, 8'd10, 10'h3FF, 1'b1);
        probe(8'd10, 8'd10, 8'd10, r1, g1, b1);
        chk(r1 == r0, "R7 red kept", r1, r0);
        chk(g1 == g0, "R7 green kept", g1, g0);
        chk(b1 == b0, "R7 blue kept", b1, b0);
    endtask

    task automatic t_no_strobe();
        logic [9:0] r1, g1, b1;
        // R10: write fields set with wr_en low
        write_entry(2'd0, 8'd20, 10'h0F0, 1'b0);
        write_entry(2'd2, 8'd20, 10'h0F0, 1'b0);
        probe(8'd20, 8'd20, 8'd20, r1, g1, b1);
        chk(r1 == mdl[20], "R10 red kept", r1, mdl[20]);
        chk(b1 == mdl[512 + 20], "R10 blue kept", b1, mdl[512 + 20]);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_bypass_unprogrammed();
        t_program();
        t_table_sweep();
        t_independent();
        t_mixed_bypass();
        t_sideband();
        t_collision();
        t_bad_chan();
        t_no_strobe();
        done = 1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            report();
        end
    end

endmodule